// File: doc/BRIEF.md
# Receive/Transmit Hardware Handshake Controller

This block performs automatic modem-line handshaking for one serial channel whose receiver is backed by a 64-entry FIFO. On the receive side, it watches the FIFO occupancy and controls the active-low request-to-send output. The output is pulled high when the FIFO is close to full and released again once the FIFO has drained well below that point. The on and off points come from a four-entry table of trigger levels, indexed by a 2-bit selector, so the two switching points are different and the line has hysteresis. The same selector sets the level at which a receive-trigger interrupt is raised.

On the transmit side, the active-low clear-to-send input passes through a synchroniser. While the automatic mode is on, the block withholds permission to start a new character whenever the remote end has deasserted that line. The serializer samples the permission only when a character starts, so a character that is already being shifted out always finishes. When either automatic mode is off, the matching line behaves as a plain signal: request-to-send mirrors the host's control bit, and transmission is always permitted.

Top module: `uart_hs_flow`

## Requirements
- R1: While reset is applied, and at its release with all enables low, `rts_n` is 1, `rx_trig_irq` is 0 and `tx_allow` is 1.
- R2: `rx_trig_irq` is 1 one clock after `rx_count` is at or above the selected trigger level, and 0 otherwise. The levels are 8, 16, 56 and 60 for `trig_sel` values 0, 1, 2 and 3.
- R3: With `auto_rts_en`=1 and `host_rts`=1, `rts_n` becomes 1 one clock after `rx_count` reaches the upper threshold. The upper threshold is the table level one step above the selected level (16, 56 or 60 for `trig_sel` 0, 1 and 2), and 64 for `trig_sel`=3.
- R4: With automatic RTS active, once `rts_n` is 1 it stays 1 until `rx_count` falls below the lower threshold, and then returns to 0 one clock later. The lower threshold is the table level one step below the selected level (8, 16 or 56 for `trig_sel` 1, 2 and 3). For `trig_sel`=0 the lower threshold is 0, and the release happens when `rx_count`=0. Between the two thresholds the previous value holds.
- R5: With `auto_rts_en`=1 but `host_rts`=0, `rts_n` stays 1 whatever the FIFO count.
- R6: With `auto_rts_en`=0, `rts_n` equals the inverse of `host_rts` one clock later, and `rx_count` has no effect on it.
- R7: Clearing `auto_rts_en` drops any held deassertion. After re-enabling with a count below the upper threshold, `rts_n` is 0.
- R8: With `auto_cts_en`=1, `tx_allow` is 0 while the synchronised `cts_n` is 1, and 1 while it is 0. With `auto_cts_en`=0, `tx_allow` is 1 regardless of `cts_n`.
- R9: A change on `cts_n` reaches `tx_allow` after exactly two rising clock edges, through a two-flop synchroniser that resets to the deasserted value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_count | input | 7 | Receive FIFO occupancy, 0 to 64 |
| trig_sel | input | 2 | Trigger level selector (0:8, 1:16, 2:56, 3:60) |
| auto_rts_en | input | 1 | Enables automatic request-to-send control |
| auto_cts_en | input | 1 | Enables automatic clear-to-send gating |
| host_rts | input | 1 | Host control bit; 1 asserts request-to-send (drives `rts_n` low) |
| cts_n | input | 1 | Active-low clear-to-send from the remote end, asynchronous |
| rts_n | output | 1 | Active-low request-to-send |
| tx_allow | output | 1 | Permission to start the next transmit character |
| rx_trig_irq | output | 1 | Receive trigger level reached |

## Verification
For every trigger selector, the FIFO count is ramped from 0 up to 64 and back down to 0 one step per clock. This separates the interrupt threshold, the upper deassertion point and the lower release point, and it shows that the line holds inside the band in both directions. The same count ramps are repeated with the host bit low and with automatic mode off, which separates the "no effect" and general-output cases from the hysteresis case. Clear-to-send edges are sampled one and two clocks after each change, which distinguishes a two-stage synchroniser from a shorter or longer one and shows that the gating disappears when its enable is off.

// File: rtl/uart_hs_flow_pkg.sv
package uart_hs_flow_pkg;

  localparam int unsigned NUM_LVL = 4;

  typedef int unsigned lvl_tab_t [NUM_LVL];

  // Receive trigger levels, in ascending order; the order sets the hysteresis band.
  localparam lvl_tab_t TRIG_TAB = '{8, 16, 56, 60};

  typedef struct packed {
    logic trig_hit;       // count at/above selected trigger level
    logic upper_hit;      // count at/above level one step up
    logic lower_release;  // count below level one step down (or empty at the bottom)
  } fill_cmp_t;

endpackage

// File: rtl/flow_thresh.sv
module flow_thresh
  import uart_hs_flow_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1),
  parameter int unsigned SEL_W = $clog2(NUM_LVL)
) (
  input  logic [CNT_W-1:0] rx_count,
  input  logic [SEL_W-1:0] trig_sel,
  output fill_cmp_t        cmp
);

  logic [CNT_W-1:0] lvl_v [NUM_LVL];
  logic [CNT_W-1:0] up_v  [NUM_LVL];
  logic [CNT_W-1:0] lo_v  [NUM_LVL];

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    assign lvl_v[g] = CNT_W'(TRIG_TAB[g]);
    if (g == NUM_LVL - 1) begin : g_top
      assign up_v[g] = CNT_W'(DEPTH);
    end else begin : g_mid_up
      assign up_v[g] = CNT_W'(TRIG_TAB[g+1]);
    end
    if (g == 0) begin : g_bot
      assign lo_v[g] = '0;
    end else begin : g_mid_lo
      assign lo_v[g] = CNT_W'(TRIG_TAB[g-1]);
    end
  end

  logic [CNT_W-1:0] sel_lvl, sel_up, sel_lo;

  always_comb begin
    sel_lvl = lvl_v[trig_sel];
    sel_up  = up_v[trig_sel];
    sel_lo  = lo_v[trig_sel];
  end

  always_comb begin
    cmp.trig_hit  = (rx_count >= sel_lvl);
    cmp.upper_hit = (rx_count >= sel_up);
    if (sel_lo == '0) begin
      cmp.lower_release = (rx_count == '0);
    end else begin
      cmp.lower_release = (rx_count < sel_lo);
    end
  end

endmodule

// File: rtl/flow_rts_ctrl.sv
module flow_rts_ctrl
  import uart_hs_flow_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  fill_cmp_t cmp,
  input  logic      auto_rts_en,
  input  logic      host_rts,
  output logic      rts_n,
  output logic      rx_trig_irq
);

  logic auto_on;
  logic hold_q, hold_d;
  logic rts_n_q, rts_n_d;
  logic irq_q, irq_d;
  logic upd_en;

  assign auto_on = auto_rts_en & host_rts;
  assign upd_en  = 1'b1;

  always_comb begin
    hold_d = hold_q;
    if (!auto_on) begin
      hold_d = 1'b0;
    end else if (cmp.upper_hit) begin
      hold_d = 1'b1;
    end else if (cmp.lower_release) begin
      hold_d = 1'b0;
    end
    rts_n_d = ~host_rts | hold_d;
    irq_d   = cmp.trig_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= 1'b0;
      rts_n_q <= 1'b1;
      irq_q   <= 1'b0;
    end else if (upd_en) begin
      hold_q  <= hold_d;
      rts_n_q <= rts_n_d;
      irq_q   <= irq_d;
    end
  end

  assign rts_n       = rts_n_q;
  assign rx_trig_irq = irq_q;

  a_r2_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    cmp.trig_hit |=> rx_trig_irq);
  a_r2_irq_clr: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp.trig_hit |=> !rx_trig_irq);
  a_r3_upper_deassert: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_on && cmp.upper_hit) |=> rts_n);
  a_r4_lower_reassert: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_on && cmp.lower_release && !cmp.upper_hit) |=> !rts_n);
  a_r5_host_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rts |=> rts_n);
  a_r6_plain_output: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rts_en |=> (rts_n == !$past(host_rts)));

endmodule

// File: rtl/flow_cts_gate.sv
module flow_cts_gate #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n,
  input  logic auto_cts_en,
  output logic tx_allow
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic cts_n_s;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], cts_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign cts_n_s  = sync_q[SYNC_STAGES-1];
  assign tx_allow = ~auto_cts_en | ~cts_n_s;

  // Cycles since reset, saturating; keeps the delay check inside history.
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= 2'd0;
    end else if (age_q != 2'd2) begin
      age_q <= age_q + 2'd1;
    end
  end

  if (SYNC_STAGES == 2) begin : g_chk2
    a_r9_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd2 && auto_cts_en) |-> (tx_allow == !$past(cts_n, 2)));
  end

  a_r8_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_cts_en && $past(sync_q[0]) && age_q == 2'd2) |-> !tx_allow);

endmodule

// File: rtl/uart_hs_flow.sv
module uart_hs_flow
  import uart_hs_flow_pkg::*;
#(
  parameter int unsigned DEPTH       = 64,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = $clog2(DEPTH + 1),
  localparam int unsigned SEL_W      = $clog2(NUM_LVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [SEL_W-1:0] trig_sel,
  input  logic             auto_rts_en,
  input  logic             auto_cts_en,
  input  logic             host_rts,
  input  logic             cts_n,
  output logic             rts_n,
  output logic             tx_allow,
  output logic             rx_trig_irq
);

  fill_cmp_t cmp;

  flow_thresh #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W),
    .SEL_W (SEL_W)
  ) u_thresh (
    .rx_count (rx_count),
    .trig_sel (trig_sel),
    .cmp      (cmp)
  );

  flow_rts_ctrl u_rts (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmp         (cmp),
    .auto_rts_en (auto_rts_en),
    .host_rts    (host_rts),
    .rts_n       (rts_n),
    .rx_trig_irq (rx_trig_irq)
  );

  flow_cts_gate #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_cts (
    .clk         (clk),
    .rst_n       (rst_n),
    .cts_n       (cts_n),
    .auto_cts_en (auto_cts_en),
    .tx_allow    (tx_allow)
  );

endmodule

// File: tb/sim_uart_hs_flow.sv
module sim_uart_hs_flow;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] rx_count;
  logic [1:0] trig_sel;
  logic       auto_rts_en, auto_cts_en, host_rts, cts_n;
  logic       rts_n, tx_allow, rx_trig_irq;

  int checks = 0;
  int errors = 0;
  bit hold_m = 1'b0;

  always #2 clk = ~clk;

  uart_hs_flow u0 (
    .clk (clk), .rst_n (rst_n), .rx_count (rx_count), .trig_sel (trig_sel),
    .auto_rts_en (auto_rts_en), .auto_cts_en (auto_cts_en), .host_rts (host_rts),
    .cts_n (cts_n), .rts_n (rts_n), .tx_allow (tx_allow), .rx_trig_irq (rx_trig_irq)
  );

  function automatic int lvl(int s);
    return (s == 0) ? 8 : (s == 1) ? 16 : (s == 2) ? 56 : 60;
  endfunction
  function automatic int upper(int s);
    return (s == 3) ? 64 : lvl(s + 1);
  endfunction
  function automatic int lower(int s);
    return (s == 0) ? 0 : lvl(s - 1);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (count=%0d sel=%0d)",
               req, act, exp, rx_count, trig_sel);
    end
  endtask

  // Drive one count value, let one edge pass, compare against the model.
  task automatic step(int c);
    int s;
    bit on, rel, exp_rts;
    string tag;
    rx_count = 7'(c);
    s = int'(trig_sel);
    @(negedge clk);
    on = auto_rts_en && host_rts;
    rel = (lower(s) == 0) ? (c == 0) : (c < lower(s));
    if (!on) hold_m = 1'b0;
    else if (c >= upper(s)) hold_m = 1'b1;
    else if (rel) hold_m = 1'b0;
    exp_rts = !host_rts || hold_m;
    if (!auto_rts_en) tag = "R6";
    else if (!host_rts) tag = "R5";
    else if (c >= upper(s)) tag = "R3";
    else tag = "R4";
    chk("R2", int'(rx_trig_irq), (c >= lvl(s)) ? 1 : 0);
    chk(tag, int'(rts_n), int'(exp_rts));
  endtask

  task automatic ramp();
    for (int c = 0; c <= 64; c++) step(c);
    for (int c = 64; c >= 0; c--) step(c);
  endtask

  initial begin
    #(4ns * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_count = '0; trig_sel = '0;
    auto_rts_en = 1'b0; auto_cts_en = 1'b0; host_rts = 1'b0; cts_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", int'(rts_n), 1);
    chk("R1", int'(rx_trig_irq), 0);
    chk("R1", int'(tx_allow), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(rts_n), 1);
    chk("R1", int'(tx_allow), 1);

    // R2/R3/R4: hysteresis sweep for every selector
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      auto_rts_en = 1'b0; host_rts = 1'b1;
      step(0);
      auto_rts_en = 1'b1;
      ramp();
    end

    // R7: hold dropped when auto disabled, re-enable below upper gives rts_n=0
    trig_sel = 2'd1;
    step(60);
    chk("R3", int'(rts_n), 1);
    auto_rts_en = 1'b0;
    step(40);
    chk("R7", int'(rts_n), 0);
    auto_rts_en = 1'b1;
    step(40);
    chk("R7", int'(rts_n), 0);

    // R5: host bit low, auto enabled, count has no effect
    host_rts = 1'b0;
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      ramp();
    end

    // R6: auto off, rts_n follows host bit only
    auto_rts_en = 1'b0;
    for (int h = 0; h < 2; h++) begin
      host_rts = h[0];
      trig_sel = 2'd2;
      ramp();
    end

    // R8/R9: clear-to-send gating and synchroniser latency
    auto_cts_en = 1'b1;
    cts_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8", int'(tx_allow), 0);
    for (int k = 0; k < 3; k++) begin
      cts_n = 1'b0;
      @(negedge clk);
      chk("R9", int'(tx_allow), 0);
      @(negedge clk);
      chk("R9", int'(tx_allow), 1);
      chk("R8", int'(tx_allow), 1);
      cts_n = 1'b1;
      @(negedge clk);
      chk("R9", int'(tx_allow), 1);
      @(negedge clk);
      chk("R8", int'(tx_allow), 0);
    end
    auto_cts_en = 1'b0;
    #1;
    chk("R8", int'(tx_allow), 1);
    cts_n = 1'b0;
    repeat (3) @(negedge clk);
    cts_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8", int'(tx_allow), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule